// File: doc/BRIEF.md
# Multiplexed Byte-Lane Write Sequencer

This block runs on the peripheral clock and turns one 32-bit write request into an asynchronous external write over a 16-bit bus that carries both address and data. Each transfer begins with an address-latch strobe. During the strobe the whole byte address is driven on all sixteen lanes. Four byte writes follow. For each write, the upper eight lanes carry the low byte of the address, with the byte index in its two lowest bits. The lower eight lanes carry one data byte, and bytes go out least significant first.

Timing is programmable. A 5-bit data-cycle count sets the write-strobe length. A flash option shortens the strobe by seven cycles and adds the same seven cycles of recovery between writes. A hold option adds one cycle of address hold after the latch strobe and one cycle of lane hold after each write strobe. A polarity bit inverts the latch strobe. Configuration is checked when a request arrives. A request with an illegal setting is refused and reported for one cycle.

Top module: `bytelane_write_seq`

## Requirements
- R1: After reset the latch strobe sits at its inactive level. The write and read strobes are high, both lane enables are 0, and busy and done are 0.
- R2: An accepted request drives the latch strobe active for exactly 2 cycles. During those cycles the bus carries the byte address {waddr, 2'b00} and both lane enables are 1.
- R3: After the latch strobe ends, the full address stays on the bus for 1 cycle if the hold option is set and for 0 cycles otherwise. The first write strobe falls exactly 2 cycles after the latch strobe deasserts.
- R4: Each write strobe is low for D - F cycles. D is the programmed count, and F is 7 in flash mode and 0 otherwise.
- R5: For write k (k = 0..3), the upper lanes [15:8] carry {addr[7:2], k} and the lower lanes [7:0] carry wdata[8k+7:8k]. Both are present one cycle before the strobe falls and stay unchanged while it is low.
- R6: After each write strobe rises, both lanes keep their values for H cycles. H is 1 with the hold option set and 0 otherwise.
- R7: From one write strobe's rising edge to the next one's falling edge there are F + H + 1 cycles.
- R8: Exactly four write strobes follow each latch strobe. Done is then high for one cycle, with both lane enables at 0. The first latch cycle counts as cycle 0, and done arrives in cycle 7 + 4D - F + 4H. Busy is high from cycle 0 through the done cycle and low afterwards.
- R9: When the polarity bit is 1, the latch strobe is active low and idles high.
- R10: A request is refused in two cases: flash mode with a count other than 9, or non-flash mode with a count of 0. A refused request raises cfg_err for exactly one cycle and starts no transfer.
- R11: A request while busy is ignored and the running transfer proceeds unchanged. The read strobe stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, sampled while idle |
| waddr | input | 14 | Word address; the byte address is {waddr, 2'b00} |
| wdata | input | 32 | Four data bytes, byte 0 in bits 7:0 |
| cfg_dur | input | 5 | Data-cycle count D |
| cfg_hold | input | 1 | Hold option enable |
| cfg_flash | input | 1 | Flash mode enable |
| cfg_ale_low | input | 1 | Latch strobe polarity, 1 = active low |
| ale | output | 1 | Address latch strobe |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, always inactive |
| bus_out | output | 16 | Multiplexed lanes, upper byte in 15:8 |
| bus_oe | output | 2 | Lane enables, bit 1 upper, bit 0 lower |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | One-cycle refused-request pulse |

## Verification
The bench targets the places where phase lengths collapse to zero: no hold with no flash, and a one-cycle strobe. A sequencer that mishandled these would stretch or merge write strobes, or show the wrong byte during setup. Flash mode combined with hold checks that the seven-cycle shortening and the added recovery land on the right side of each strobe. A wrong split would show up as a strobe width or gap off by seven. The longest count and the inverted latch polarity are also run, along with refused configurations that must not start a transfer. A request held high through a whole transfer checks that the sequencer does not restart or shorten the transfer.

// File: rtl/pwseq_pkg.sv
package pwseq_pkg;
   localparam int DUR_W = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALE,
      ST_AHOLD,
      ST_SETUP,
      ST_STROBE,
      ST_DHOLD,
      ST_RECOV,
      ST_DONE
   } pw_state_e;

   typedef struct packed {
      logic [DUR_W-1:0] dur;
      logic             hold;
      logic             flash;
   } pw_cfg_t;
endpackage

// File: rtl/pwseq_timer.sv
module pwseq_timer #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expire = (cnt_q == '0);

   // R4
   load_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> expire);
endmodule

// File: rtl/pwseq_ctrl.sv
module pwseq_ctrl
   import pwseq_pkg::*;
#(
   parameter int BEATS     = 4,
   parameter int ALE_CYC   = 2,
   parameter int ALE_TO_WR = 2,
   parameter int FLASH_DLY = 7,
   parameter int FLASH_DUR = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  pw_cfg_t                  cfg_in,
   input  logic                     tmr_expire,
   output logic                     tmr_load,
   output logic [DUR_W-1:0]         tmr_val,
   output pw_state_e                state,
   output logic [$clog2(BEATS)-1:0] byte_idx,
   output logic                     accept,
   output logic                     busy,
   output logic                     done,
   output logic                     cfg_err
);
   localparam int IDX_W = $clog2(BEATS);

   pw_cfg_t   cfg_q;
   pw_state_e nxt, cand;
   logic      last, first, cfg_bad, advance;
   int        nlen;

   function automatic int phase_len(pw_state_e s, logic is_first, pw_cfg_t c);
      int h;
      h = c.hold ? 1 : 0;
      case (s)
         ST_ALE:    return ALE_CYC;
         ST_AHOLD:  return h;
         ST_SETUP:  return is_first ? (ALE_TO_WR - h) : 1;
         ST_STROBE: return c.flash ? (int'(c.dur) - FLASH_DLY) : int'(c.dur);
         ST_DHOLD:  return h;
         ST_RECOV:  return c.flash ? FLASH_DLY : 0;
         ST_DONE:   return 1;
         default:   return 0;
      endcase
   endfunction

   function automatic pw_state_e succ(pw_state_e s, logic is_last);
      case (s)
         ST_ALE:    return ST_AHOLD;
         ST_AHOLD:  return ST_SETUP;
         ST_SETUP:  return ST_STROBE;
         ST_STROBE: return ST_DHOLD;
         ST_DHOLD:  return is_last ? ST_DONE : ST_RECOV;
         ST_RECOV:  return ST_SETUP;
         default:   return ST_IDLE;
      endcase
   endfunction

   always_comb begin
      last    = (byte_idx == IDX_W'(BEATS - 1));
      first   = (state == ST_ALE) || (state == ST_AHOLD);
      cfg_bad = cfg_in.flash ? (cfg_in.dur != DUR_W'(FLASH_DUR)) : (cfg_in.dur == '0);
      accept  = (state == ST_IDLE) && start && !cfg_bad;
      cand    = ST_IDLE;
      nxt     = state;
      advance = 1'b0;
      if (accept) begin
         nxt     = ST_ALE;
         advance = 1'b1;
      end else if ((state != ST_IDLE) && tmr_expire) begin
         cand = succ(state, last);
         for (int i = 0; i < 2; i++) begin
            if ((cand != ST_IDLE) && (phase_len(cand, first, cfg_q) == 0))
               cand = succ(cand, last);
         end
         nxt     = cand;
         advance = 1'b1;
      end
      nlen     = (nxt == ST_IDLE) ? 0 : phase_len(nxt, first, cfg_q);
      tmr_load = advance;
      tmr_val  = (nlen > 0) ? DUR_W'(nlen - 1) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cfg_q    <= '0;
         byte_idx <= '0;
         cfg_err  <= 1'b0;
      end else begin
         state   <= nxt;
         cfg_err <= (state == ST_IDLE) && start && cfg_bad;
         if (accept) begin
            cfg_q    <= cfg_in;
            byte_idx <= '0;
         end else if (advance && (nxt == ST_SETUP) && !first) begin
            byte_idx <= byte_idx + 1'b1;
         end
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_DONE);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   cfg_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !busy);
   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

// File: rtl/pwseq_lanes.sv
module pwseq_lanes
   import pwseq_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int BEATS  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          capture,
   input  logic [2*BYTE_W-$clog2(BEATS)-1:0] waddr,
   input  logic [BEATS*BYTE_W-1:0]       wdata,
   input  pw_state_e                     state,
   input  logic [$clog2(BEATS)-1:0]      byte_idx,
   input  logic                          ale_low,
   output logic                          ale_act,
   output logic                          ale,
   output logic                          wr_n,
   output logic [2*BYTE_W-1:0]           bus_out,
   output logic [1:0]                    bus_oe
);
   localparam int IDX_W = $clog2(BEATS);
   localparam int BUS_W = 2 * BYTE_W;
   localparam int WA_W  = BUS_W - IDX_W;

   logic [WA_W-1:0]         waddr_q;
   logic [BEATS*BYTE_W-1:0] wdata_q;
   logic [BYTE_W-1:0]       byte_arr [BEATS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waddr_q <= '0;
         wdata_q <= '0;
      end else if (capture) begin
         waddr_q <= waddr;
         wdata_q <= wdata;
      end
   end

   for (genvar g = 0; g < BEATS; g++) begin : g_bytes
      assign byte_arr[g] = wdata_q[g*BYTE_W +: BYTE_W];
   end

   always_comb begin
      bus_out = '0;
      bus_oe  = 2'b00;
      case (state)
         ST_ALE, ST_AHOLD: begin
            bus_out = {waddr_q, IDX_W'(0)};
            bus_oe  = 2'b11;
         end
         ST_SETUP, ST_STROBE, ST_DHOLD, ST_RECOV: begin
            bus_out = {waddr_q[BYTE_W-IDX_W-1:0], byte_idx, byte_arr[byte_idx]};
            bus_oe  = 2'b11;
         end
         default: ;
      endcase
   end

   assign ale_act = (state == ST_ALE);
   assign ale     = ale_act ^ ale_low;
   assign wr_n    = (state != ST_STROBE);

   // R5
   lane_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && $past(!wr_n)) |-> $stable(bus_out));
   // R2
   ale_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale_act |-> (bus_oe == 2'b11));
endmodule

// File: rtl/bytelane_write_seq.sv
module bytelane_write_seq
   import pwseq_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int BEATS     = 4,
   parameter int ALE_CYC   = 2,
   parameter int ALE_TO_WR = 2,
   parameter int FLASH_DLY = 7,
   parameter int FLASH_DUR = 9
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  start,
   input  logic [2*BYTE_W-$clog2(BEATS)-1:0]     waddr,
   input  logic [BEATS*BYTE_W-1:0]               wdata,
   input  logic [DUR_W-1:0]                      cfg_dur,
   input  logic                                  cfg_hold,
   input  logic                                  cfg_flash,
   input  logic                                  cfg_ale_low,
   output logic                                  ale,
   output logic                                  wr_n,
   output logic                                  rd_n,
   output logic [2*BYTE_W-1:0]                   bus_out,
   output logic [1:0]                            bus_oe,
   output logic                                  busy,
   output logic                                  done,
   output logic                                  cfg_err
);
   localparam int IDX_W = $clog2(BEATS);
   localparam int CNT_W = IDX_W + 2;

   initial begin : elab_chk
      beats_pow2_chk: assert (BEATS == (1 << IDX_W) && BEATS >= 2)
         else $error("beat count must be a power of two");
      lane_room_chk: assert (BYTE_W > IDX_W)
         else $error("byte lane too narrow for the index");
      flash_fit_chk: assert (FLASH_DUR > FLASH_DLY && FLASH_DUR < (1 << DUR_W))
         else $error("flash count out of range");
      gap_chk: assert (ALE_TO_WR >= 2 && ALE_CYC >= 1)
         else $error("latch timing too short");
   end

   pw_cfg_t          cfg_in;
   pw_state_e        state;
   logic [IDX_W-1:0] byte_idx;
   logic             accept, tmr_load, tmr_expire, ale_act;
   logic [DUR_W-1:0] tmr_val;

   assign cfg_in = '{dur: cfg_dur, hold: cfg_hold, flash: cfg_flash};

   pwseq_ctrl #(
      .BEATS(BEATS), .ALE_CYC(ALE_CYC), .ALE_TO_WR(ALE_TO_WR),
      .FLASH_DLY(FLASH_DLY), .FLASH_DUR(FLASH_DUR)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
      .tmr_expire(tmr_expire), .tmr_load(tmr_load), .tmr_val(tmr_val),
      .state(state), .byte_idx(byte_idx), .accept(accept),
      .busy(busy), .done(done), .cfg_err(cfg_err)
   );

   pwseq_timer #(.W(DUR_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .expire(tmr_expire)
   );

   pwseq_lanes #(.BYTE_W(BYTE_W), .BEATS(BEATS)) i_lanes (
      .clk(clk), .rst_n(rst_n), .capture(accept), .waddr(waddr), .wdata(wdata),
      .state(state), .byte_idx(byte_idx), .ale_low(cfg_ale_low),
      .ale_act(ale_act), .ale(ale), .wr_n(wr_n), .bus_out(bus_out), .bus_oe(bus_oe)
   );

   assign rd_n = 1'b1;

   logic             wr_n_d;
   logic [CNT_W-1:0] fall_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_n_d   <= 1'b1;
         fall_cnt <= '0;
      end else begin
         wr_n_d <= wr_n;
         if (accept)                fall_cnt <= '0;
         else if (wr_n_d && !wr_n)  fall_cnt <= fall_cnt + 1'b1;
      end
   end

   // R2
   ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale_act) |=> ale_act ##1 !ale_act);
   // R3
   ale_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale_act) |-> wr_n ##1 wr_n);
   // R8
   four_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fall_cnt == CNT_W'(BEATS)));
   // R8
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bus_oe == 2'b00) && wr_n);
endmodule

// File: tb/test_bytelane_write_seq.sv
module test_bytelane_write_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;

   typedef struct packed {
      logic [4:0]  dur;
      logic        hold;
      logic        flash;
      logic        alelow;
      logic [15:0] addr;
      logic [31:0] data;
      logic [7:0]  width;
      logic [7:0]  gap;
      logic [7:0]  done_t;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{5'd3,  1'b0, 1'b0, 1'b0, 16'h1234, 32'hA1B2C3D4, 8'd3,  8'd1, 8'd19},
      '{5'd5,  1'b1, 1'b0, 1'b0, 16'hBEE8, 32'h01020304, 8'd5,  8'd2, 8'd31},
      '{5'd9,  1'b0, 1'b1, 1'b0, 16'h0F00, 32'hDEADBEEF, 8'd2,  8'd8, 8'd36},
      '{5'd9,  1'b1, 1'b1, 1'b1, 16'hFFFC, 32'h55AA33CC, 8'd2,  8'd9, 8'd40},
      '{5'd1,  1'b0, 1'b0, 1'b1, 16'h0004, 32'h80FF7F00, 8'd1,  8'd1, 8'd11},
      '{5'd31, 1'b1, 1'b0, 1'b0, 16'h8000, 32'h11223344, 8'd31, 8'd2, 8'd135}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [13:0] waddr = '0;
   logic [31:0] wdata = '0;
   logic [4:0]  cfg_dur = 5'd3;
   logic        cfg_hold = 1'b0;
   logic        cfg_flash = 1'b0;
   logic        cfg_ale_low = 1'b0;
   logic        ale, wr_n, rd_n, busy, done, cfg_err;
   logic [15:0] bus_out;
   logic [1:0]  bus_oe;

   int n_chk = 0;
   int n_fail = 0;
   int last_nwr = 0;
   int last_done = -1;

   always #(CLK_PERIOD/2) clk = ~clk;

   bytelane_write_seq i_bytelane_write_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .waddr(waddr), .wdata(wdata),
      .cfg_dur(cfg_dur), .cfg_hold(cfg_hold), .cfg_flash(cfg_flash),
      .cfg_ale_low(cfg_ale_low), .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
      .bus_out(bus_out), .bus_oe(bus_oe), .busy(busy), .done(done), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] lane(vec_t v, int k);
      return {v.addr[7:2], 2'(k), v.data[8*k +: 8]};
   endfunction

   task automatic run_xfer(input vec_t v, input bit keep_start);
      int t = 0, ale_n = 0, ale_end = -1, first_fall = -1, last_rise = -1;
      int fall_t = 0, nwr = 0, done_t = -1;
      bit ale_bus_ok = 1, ahold_ok = 1, setup_ok = 1, data_ok = 1, width_ok = 1;
      bit dhold_ok = 1, gap_ok = 1, rd_ok = 1, rel_ok = 1;
      logic prev_wr = 1'b1, prev_act = 1'b0, act;
      logic [15:0] prev_bus = '0;
      @(negedge clk);
      cfg_dur = v.dur; cfg_hold = v.hold; cfg_flash = v.flash; cfg_ale_low = v.alelow;
      waddr = v.addr[15:2]; wdata = v.data; start = 1'b1;
      @(negedge clk);
      if (!keep_start) start = 1'b0;
      while (t < 300 && done_t < 0) begin
         act = ale ^ v.alelow;
         if (act) begin
            ale_n++;
            if (bus_out !== v.addr || bus_oe !== 2'b11) ale_bus_ok = 0;
         end
         if (!act && prev_act) begin
            ale_end = t;
            if (v.hold && bus_out !== v.addr) ahold_ok = 0;
         end
         if (rd_n !== 1'b1) rd_ok = 0;
         if (!wr_n && prev_wr) begin
            if (nwr < 4 && prev_bus !== lane(v, nwr)) setup_ok = 0;
            if (nwr == 0) first_fall = t;
            else if (t - last_rise != int'(v.gap)) gap_ok = 0;
            fall_t = t;
         end
         if (!wr_n && nwr < 4 && bus_out !== lane(v, nwr)) data_ok = 0;
         if (wr_n && !prev_wr) begin
            if (t - fall_t != int'(v.width)) width_ok = 0;
            if (v.hold && nwr < 4 && bus_out !== lane(v, nwr)) dhold_ok = 0;
            last_rise = t;
            nwr++;
         end
         if (done) begin
            done_t = t;
            if (bus_oe !== 2'b00 || !busy) rel_ok = 0;
         end
         prev_wr = wr_n; prev_act = act; prev_bus = bus_out;
         t++;
         @(negedge clk);
      end
      start = 1'b0;
      check(ale_n == 2, "R2", "latch strobe cycles", ale_n, 2);
      check(ale_bus_ok, "R2", "address on lanes during latch", ale_bus_ok, 1);
      check(ahold_ok, "R3", "address hold after latch", ahold_ok, 1);
      check(first_fall - ale_end == 2, "R3", "latch end to first write", first_fall - ale_end, 2);
      check(width_ok, "R4", "write strobe width", width_ok, 1);
      check(setup_ok && data_ok, "R5", "byte address and data lanes", setup_ok && data_ok, 1);
      check(dhold_ok, "R6", "lane hold after write", dhold_ok, 1);
      check(gap_ok, "R7", "write rise to next fall", gap_ok, 1);
      check(nwr == 4, "R8", "writes per latch", nwr, 4);
      check(done_t == int'(v.done_t) && rel_ok, "R8", "done cycle", done_t, v.done_t);
      check(rd_ok, "R11", "read strobe inactive", rd_ok, 1);
      check(busy == 1'b0, "R8", "busy after done", busy, 0);
      check(ale == v.alelow, "R9", "latch idle level", ale, v.alelow);
      last_nwr = nwr;
      last_done = done_t;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      #(CLK_PERIOD * 2 + 2);
      // R1 reset state
      check(ale == 1'b0, "R1", "ale in reset", ale, 0);
      check(wr_n == 1'b1 && rd_n == 1'b1, "R1", "strobes in reset", {wr_n, rd_n}, 3);
      check(bus_oe == 2'b00 && !busy && !done, "R1", "enables and status in reset", bus_oe, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && bus_oe == 2'b00 && wr_n, "R1", "idle after reset", busy, 0);

      for (int i = 0; i < NVEC; i++) run_xfer(VECS[i], 1'b0);

      // R9 idle polarity follows the configuration bit
      @(negedge clk);
      cfg_ale_low = 1'b1;
      #1;
      check(ale == 1'b1, "R9", "active-low idle level", ale, 1);
      cfg_ale_low = 1'b0;

      // R10 flash with wrong count
      @(negedge clk);
      cfg_flash = 1'b1; cfg_dur = 5'd8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(cfg_err == 1'b1 && !busy, "R10", "flash count 8 refused", cfg_err, 1);
      @(negedge clk);
      check(cfg_err == 1'b0 && !busy && ale == 1'b0, "R10", "refusal pulse ends", cfg_err, 0);

      // R10 zero count without flash
      cfg_flash = 1'b0; cfg_dur = 5'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(cfg_err == 1'b1 && !busy, "R10", "count 0 refused", cfg_err, 1);
      @(negedge clk);
      check(!busy && bus_oe == 2'b00, "R10", "no transfer after refusal", busy, 0);

      // R11 request held high through a transfer
      run_xfer(VECS[0], 1'b1);
      check(last_nwr == 4 && last_done == 19, "R11", "held request does not restart",
            last_done, 19);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule